// File: doc/BRIEF.md
# Prescaled Tap-Selected Counter

This block is a 32-bit up-counter whose count rate comes from a hidden 32-bit prescaler. The prescaler advances once for each cycle in which the block is enabled and the prescaler tick input is high. A runtime tap-select value picks one prescaler bit. Each 0-to-1 transition of that bit advances the counter by one. Selecting bit `p` therefore gives a count rate of the tick rate divided by 2^(p+1).

Software cannot see the prescaler, but it can reset it to zero with a clear strobe. The counter value can be read at all times and loaded through a write strobe. The counter wraps from all-ones to zero. An alarm strobe, when its reset option is on, forces the counter to zero. Both events set a sticky overflow flag, which software clears by writing a one to it.

A mode bit chooses between plain counting and a held state. In the held state the counter does not advance.

Top module: `tap_counter`

## Requirements
- R1: When `enable` is high, each cycle with `tickEn` high advances the prescaler by one. When `enable` is low, the prescaler is frozen and the counter never advances or resets from an alarm.
- R2: A cycle with `prescClr` high sets the prescaler to zero, whether or not the block is enabled. This falling of the tap bit produces no count.
- R3: A `tapSel` value of p selects prescaler bit p. The counter advances by exactly one on each 0-to-1 transition of that bit, and on nothing else. The change appears two clock edges after the tick that caused the transition.
- R4: When `tapSel` changes, the newly selected bit is resampled without producing a count. This holds even if the new bit is 1 while the old bit was 0.
- R5: When the counter advances from 0xFFFFFFFF, it wraps to 0x00000000 and sets `ovfFlag`.
- R6: When `enable` and `alarmRstEn` are both high, a cycle with `alarmStrobe` high sets the counter to zero and sets `ovfFlag`. With `alarmRstEn` low, the strobe changes neither the counter nor the flag.
- R7: A cycle with `cntWrEn` high loads `cntWrData` into the counter at the next edge. This load wins over an increment or an alarm reset in the same cycle.
- R8: `ovfFlag` stays set until a cycle with `ovfWrEn` high and `ovfWrData` equal to 1. With `ovfWrData` equal to 0, the write has no effect. A new overflow event in the same cycle keeps the flag set.
- R9: With `modeCal` high, the counter holds its value and does not advance on tap edges.
- R10: After reset, `cntValue` is 0 and `ovfFlag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable |
| tickEn | input | 1 | Prescaler clock tick |
| prescClr | input | 1 | Prescaler clear strobe |
| tapSel | input | 5 | Prescaler bit used as count source |
| modeCal | input | 1 | 1 = hold counter, 0 = plain counting |
| alarmRstEn | input | 1 | Allow alarm strobe to reset counter |
| alarmStrobe | input | 1 | Alarm event |
| cntWrEn | input | 1 | Counter write strobe |
| cntWrData | input | 32 | Counter write value |
| ovfWrEn | input | 1 | Overflow flag write strobe |
| ovfWrData | input | 1 | Overflow flag write value (1 clears) |
| cntValue | output | 32 | Current counter value |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
The prescaler is invisible, so a fault in it or in the edge detector shows up only as a wrong count. The bench therefore clears the prescaler, applies a known number of ticks at a chosen tap, and compares the final count against the closed-form number of rising transitions. A stale tap sample or an unsuppressed tap change adds one spurious count within two cycles of the tap change. A lost write priority or a missed wrap shows up at `cntValue` and `ovfFlag` one edge after the triggering cycle.

// File: rtl/tapcnt_pkg.sv
package tapcnt_pkg;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic cntLoad;   // load software value
    logic cntZero;   // alarm-forced reset
    logic cntInc;    // advance by one
    logic ovfSet;    // overflow event
    logic ovfClr;    // software clear request
  } tapcnt_strobe_t;

endpackage

// File: rtl/tapcnt_datapath.sv
module tapcnt_datapath
  import tapcnt_pkg::*;
#(
  parameter int PRESC_W = 32,
  parameter int CNT_W   = 32,
  parameter int SEL_W   = $clog2(PRESC_W)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 prescStep,
  input  logic                 prescClr,
  input  logic [SEL_W-1:0]     tapSel,
  input  tapcnt_strobe_t       st,
  input  logic [CNT_W-1:0]     cntWrData,
  output logic                 tapBit,
  output logic                 cntAtMax,
  output logic [CNT_W-1:0]     cntValue
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [PRESC_W-1:0] presc;
  logic [CNT_W-1:0]   cnt;

  // hidden prescaler; clear beats a tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          presc <= '0;
    else if (prescClr)  presc <= '0;
    else if (prescStep) presc <= presc + PRESC_W'(1);
  end

  // tap multiplexer: one-hot compare per bit, folded with OR
  logic [PRESC_W-1:0] tapHit;
  genvar gi;
  generate
    for (gi = 0; gi < PRESC_W; gi++) begin : g_tap
      assign tapHit[gi] = presc[gi] && (tapSel == SEL_W'(gi));
    end
  endgenerate
  assign tapBit = |tapHit;

  // counter: load > zero > increment
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (st.cntLoad) cnt <= cntWrData;
    else if (st.cntZero) cnt <= '0;
    else if (st.cntInc)  cnt <= cnt + CNT_W'(1);
  end

  assign cntAtMax = (cnt == CNT_MAX);
  assign cntValue = cnt;

endmodule

// File: rtl/tapcnt_ctrl.sv
module tapcnt_ctrl
  import tapcnt_pkg::*;
#(
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             modeCal,
  input  logic             alarmRstEn,
  input  logic             alarmStrobe,
  input  logic             cntWrEn,
  input  logic             ovfWrEn,
  input  logic             ovfWrData,
  input  logic [SEL_W-1:0] tapSel,
  input  logic             tapBit,
  input  logic             cntAtMax,
  output tapcnt_strobe_t   st,
  output logic             ovfFlag
);

  logic             tapPrev;
  logic [SEL_W-1:0] selPrev;
  logic             tapRise;
  logic             alarmHit;
  logic             incReq;
  logic             ovfQ;

  // edge detector; a tap change only resamples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tapPrev <= 1'b0;
      selPrev <= '0;
    end else begin
      tapPrev <= tapBit;
      selPrev <= tapSel;
    end
  end

  assign tapRise  = tapBit && !tapPrev && (tapSel == selPrev);
  assign alarmHit = enable && alarmRstEn && alarmStrobe;
  assign incReq   = enable && !modeCal && tapRise;

  always_comb begin
    st         = '0;
    st.cntLoad = cntWrEn;
    st.cntZero = !cntWrEn && alarmHit;
    st.cntInc  = !cntWrEn && !alarmHit && incReq;
    st.ovfSet  = st.cntZero || (st.cntInc && cntAtMax);
    st.ovfClr  = ovfWrEn && ovfWrData;
  end

  // sticky flag; a new event wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ovfQ <= 1'b0;
    else if (st.ovfSet) ovfQ <= 1'b1;
    else if (st.ovfClr) ovfQ <= 1'b0;
  end

  assign ovfFlag = ovfQ;

endmodule

// File: rtl/tap_counter.sv
module tap_counter
  import tapcnt_pkg::*;
#(
  parameter int PRESC_W = 32,
  parameter int CNT_W   = 32,
  parameter int SEL_W   = $clog2(PRESC_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             tickEn,
  input  logic             prescClr,
  input  logic [SEL_W-1:0] tapSel,
  input  logic             modeCal,
  input  logic             alarmRstEn,
  input  logic             alarmStrobe,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             ovfWrEn,
  input  logic             ovfWrData,
  output logic [CNT_W-1:0] cntValue,
  output logic             ovfFlag
);

  tapcnt_strobe_t st;
  logic           tapBit;
  logic           cntAtMax;

  tapcnt_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .modeCal    (modeCal),
    .alarmRstEn (alarmRstEn),
    .alarmStrobe(alarmStrobe),
    .cntWrEn    (cntWrEn),
    .ovfWrEn    (ovfWrEn),
    .ovfWrData  (ovfWrData),
    .tapSel     (tapSel),
    .tapBit     (tapBit),
    .cntAtMax   (cntAtMax),
    .st         (st),
    .ovfFlag    (ovfFlag)
  );

  tapcnt_datapath #(.PRESC_W(PRESC_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .prescStep(enable && tickEn),
    .prescClr (prescClr),
    .tapSel   (tapSel),
    .st       (st),
    .cntWrData(cntWrData),
    .tapBit   (tapBit),
    .cntAtMax (cntAtMax),
    .cntValue (cntValue)
  );

endmodule

// File: rtl/tapcnt_chk.sv
module tapcnt_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             modeCal,
  input logic             alarmRstEn,
  input logic             alarmStrobe,
  input logic             cntWrEn,
  input logic [CNT_W-1:0] cntWrData,
  input logic             ovfWrEn,
  input logic             ovfWrData,
  input logic [CNT_W-1:0] cntValue,
  input logic             ovfFlag
);

  // R5 R6
  ovf_rise_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> (cntValue == '0));

  // R7
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntWrEn |=> (cntValue == $past(cntWrData)));

  // R6
  alarm_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && alarmRstEn && alarmStrobe && !cntWrEn) |=> (cntValue == '0 && ovfFlag));

  // R9
  hold_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeCal && !cntWrEn && !(enable && alarmRstEn && alarmStrobe)) |=> $stable(cntValue));

  // R1
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !cntWrEn) |=> $stable(cntValue));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cntWrEn && !(enable && alarmRstEn && alarmStrobe)) |=>
      (cntValue == $past(cntValue) || cntValue == $past(cntValue) + CNT_W'(1)));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(ovfWrEn && ovfWrData)) |=> ovfFlag);

endmodule

bind tap_counter tapcnt_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tap_counter_tb.sv
module tap_counter_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b1;
  logic        tickEn = 1'b0;
  logic        prescClr = 1'b0;
  logic [4:0]  tapSel = '0;
  logic        modeCal = 1'b0;
  logic        alarmRstEn = 1'b0;
  logic        alarmStrobe = 1'b0;
  logic        cntWrEn = 1'b0;
  logic [31:0] cntWrData = '0;
  logic        ovfWrEn = 1'b0;
  logic        ovfWrData = 1'b0;
  logic [31:0] cntValue;
  logic        ovfFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tap_counter u_dut (.*);

  // {tap, ticks, expected count} after prescaler clear
  localparam logic [47:0] VEC [0:7] = '{
    {8'd0, 8'd10,  32'd5},
    {8'd1, 8'd10,  32'd3},
    {8'd2, 8'd20,  32'd3},
    {8'd3, 8'd7,   32'd0},
    {8'd3, 8'd8,   32'd1},
    {8'd0, 8'd1,   32'd1},
    {8'd4, 8'd50,  32'd2},
    {8'd5, 8'd100, 32'd2}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // clear prescaler and load counter, then apply ticks, then settle
  task automatic runTicks(input logic [4:0] p, input int n, input logic [31:0] init);
    tapSel = p; tickEn = 1'b0; prescClr = 1'b1; cntWrEn = 1'b1; cntWrData = init;
    cyc(1);
    prescClr = 1'b0; cntWrEn = 1'b0;
    tickEn = (n > 0);
    cyc(n);
    tickEn = 1'b0;
    cyc(2);
  endtask

  initial begin
    cyc(2);
    rstN = 1'b1;
    cyc(1);
    // R10
    chk("R10 count after reset", cntValue, 32'd0);
    chk("R10 flag after reset", {31'd0, ovfFlag}, 32'd0);

    // R3 rate table
    for (int v = 0; v < 8; v++) begin
      runTicks(VEC[v][44:40], int'(VEC[v][39:32]), 32'd0);
      chk("R3 tap rate", cntValue, VEC[v][31:0]);
    end

    // R5 wrap
    runTicks(5'd0, 1, 32'hFFFF_FFFF);
    chk("R5 wrap value", cntValue, 32'd0);
    chk("R5 wrap flag", {31'd0, ovfFlag}, 32'd1);

    // R8 write zero ignored, write one clears
    ovfWrEn = 1'b1; ovfWrData = 1'b0; cyc(1); ovfWrEn = 1'b0; cyc(1);
    chk("R8 zero write keeps flag", {31'd0, ovfFlag}, 32'd1);
    ovfWrEn = 1'b1; ovfWrData = 1'b1; cyc(1); ovfWrEn = 1'b0; cyc(1);
    chk("R8 one write clears flag", {31'd0, ovfFlag}, 32'd0);

    // R2 prescaler clear: 3 ticks, clear, 2 ticks on bit 1
    runTicks(5'd1, 3, 32'd0);
    prescClr = 1'b1; cyc(1); prescClr = 1'b0;
    tickEn = 1'b1; cyc(2); tickEn = 1'b0; cyc(2);
    chk("R2 clear restarts prescaler", cntValue, 32'd2);

    // R4 tap change: prescaler at 2, switch bit0 -> bit1
    runTicks(5'd0, 2, 32'd0);
    tapSel = 5'd1; cyc(3);
    chk("R4 no false edge on tap change", cntValue, 32'd1);

    // R7 write wins over increment in same cycle
    runTicks(5'd0, 0, 32'd0);
    tickEn = 1'b1; cyc(1);
    tickEn = 1'b0; cntWrEn = 1'b1; cntWrData = 32'h55; cyc(1);
    cntWrEn = 1'b0; cyc(2);
    chk("R7 write priority", cntValue, 32'h55);

    // R1 disabled: ticks ignored
    enable = 1'b0;
    runTicks(5'd0, 6, 32'd7);
    chk("R1 disabled no count", cntValue, 32'd7);
    enable = 1'b1;

    // R9 hold mode
    modeCal = 1'b1;
    runTicks(5'd0, 6, 32'd9);
    chk("R9 hold mode", cntValue, 32'd9);
    modeCal = 1'b0;

    // R6 alarm ignored, then applied
    runTicks(5'd0, 0, 32'h1234);
    alarmRstEn = 1'b0; alarmStrobe = 1'b1; cyc(1); alarmStrobe = 1'b0; cyc(1);
    chk("R6 alarm ignored value", cntValue, 32'h1234);
    chk("R6 alarm ignored flag", {31'd0, ovfFlag}, 32'd0);
    alarmRstEn = 1'b1; alarmStrobe = 1'b1; cyc(1); alarmStrobe = 1'b0; cyc(1);
    chk("R6 alarm reset value", cntValue, 32'd0);
    chk("R6 alarm reset flag", {31'd0, ovfFlag}, 32'd1);
    alarmRstEn = 1'b0;

    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule